// File: doc/BRIEF.md
# Serial Controller Register and Interrupt Block

This block is the register front end of a byte-serial I/O controller. A host reaches it over a 32-bit register bus. The bus carries a request, a write flag, a byte address and four byte enables, and the byte lanes are big-endian. The block holds the control words for the line, the interrupt enables, the interrupt flags, the FIFO control and the baud setting. It also holds two 16-entry byte FIFOs. One carries characters towards the line and the other carries characters from it.

The line side is reached through two ready/valid byte streams. One drains the transmit FIFO and the other fills the receive FIFO. Bit timing, framing, parity and flow control are left to the logic on the line side. A single level interrupt is raised while any enabled status flag is set.

Reads return data combinationally in the cycle of the request. Any side effect of an access takes place at the clock edge that ends that cycle. Side effects include a FIFO push, a FIFO pop, a flag clear and a FIFO clear.

Top module: `sio_ctrl_regs`

## Requirements
- R1: After reset:
  - The line control word reads 0x40000000 and the baud word reads 0x03FF0000.
  - The interrupt control, FIFO control and line status words read 0.
  - Both FIFOs are empty, so `tx_valid_o` is 0 and `rx_ready_o` is 1.
  - `irq_o` is 0.
- R2: Registers are decoded from `addr_i[7:2]` inside a 0x100-byte window, and `addr_i[1:0]` are ignored. The word offsets are:
  - line control 0x00
  - line status 0x04
  - interrupt control 0x08
  - interrupt status 0x0C
  - FIFO control 0x10
  - baud 0x14
  - transmit data 0x20
  - receive data 0x30

  Any other offset reads 0 and ignores writes.
- R3: `be_i[3]` selects bits 31:24 (byte offset 0), `be_i[2]` bits 23:16, `be_i[1]` bits 15:8 and `be_i[0]` bits 7:0. A write replaces only the enabled lanes.
- R4: After the lane merge, each written word is ANDed with a fixed mask:
  - line control 0xE17F0000
  - interrupt control 0x000F0000
  - interrupt status 0x00070000
  - FIFO control 0x001F0000
  - baud 0x03FF0000

  The line status word is read-only and reads 0.
- R5: Interrupt status bit 16 sets while the receive FIFO is non-empty, and bit 17 sets while the transmit FIFO is empty. A set flag stays set until software clears it.
- R6: A status write ANDs each enabled lane with the current flags, so it can only clear them. A flag whose condition still holds sets again one cycle after the write.
- R7: `irq_o` is high exactly while (status AND interrupt control) is non-zero over bits 18:16. Bit 16 enables the receive interrupt, bit 17 the transmit interrupt and bit 18 the error interrupt. Bit 19 (DMA enable) is stored and has no effect.
- R8: In the FIFO control word, bit 16 is the reset enable, bit 17 resets the receive FIFO and bit 18 resets the transmit FIFO. A FIFO clears on a FIFO control write only when the resulting word has the enable bit and that FIFO's bit both set.
- R9: A write to transmit data with `be_i[3]` set pushes `wdata_i[31:24]`. A write without `be_i[3]` does not push. A push to a full FIFO is dropped. Characters leave on `tx_data_o` in push order, and reads of transmit data return 0.
- R10: A read of receive data with `be_i[3]` set pops one character when the FIFO is non-empty and returns it in bits 31:24. Any other read of receive data returns 0 and does not pop.
- R11: `rx_ready_o` is high while the receive FIFO holds fewer than 16 characters. A character is stored when `rx_valid_i` and `rx_ready_o` are both high.
- R12: The baud word is storage only and does not change stream or FIFO behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address within the window |
| be_i | input | 4 | Byte enables, bit 3 = bits 31:24 |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the request cycle |
| tx_valid_o | output | 1 | Transmit character available |
| tx_data_o | output | 8 | Transmit character |
| tx_ready_i | input | 1 | Line side takes the transmit character |
| rx_valid_i | input | 1 | Received character offered |
| rx_data_i | input | 8 | Received character |
| rx_ready_o | output | 1 | Receive FIFO has room |
| irq_o | output | 1 | Level interrupt |

## Verification
Register storage is exercised with random offsets, random byte-enable patterns and random data, including unmapped offsets and nonzero low address bits. Each access is read back against a merge-and-mask model, which separates lane-selection errors from mask errors. The FIFOs are driven with directed sequences:
- in-order drain
- overfill past 16
- partial-lane pushes and pops
- reads of an empty FIFO

The interrupt path is driven by clearing flags while their condition still holds and while it no longer holds. It is also driven by writing ones to the status word and by enabling only the DMA bit. Together these separate a true clear-only write from a plain store, and a masked interrupt from an unmasked one.

// File: rtl/sio_pkg.sv
package sio_pkg;

  localparam int unsigned DW = 32;

  localparam logic [DW-1:0] LCR_MASK  = 32'hE17F_0000;
  localparam logic [DW-1:0] ICTL_MASK = 32'h000F_0000;
  localparam logic [DW-1:0] STS_MASK  = 32'h0007_0000;
  localparam logic [DW-1:0] FCTL_MASK = 32'h001F_0000;
  localparam logic [DW-1:0] BAUD_MASK = 32'h03FF_0000;

  localparam logic [DW-1:0] LCR_RST  = 32'h4000_0000;
  localparam logic [DW-1:0] BAUD_RST = 32'h03FF_0000;

  localparam int unsigned BIT_RX   = 16;
  localparam int unsigned BIT_TX   = 17;
  localparam int unsigned BIT_ERR  = 18;
  localparam int unsigned BIT_FEN  = 16;
  localparam int unsigned BIT_FRX  = 17;
  localparam int unsigned BIT_FTX  = 18;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_LCR, SEL_LSR, SEL_ICTL, SEL_STS,
    SEL_FCTL, SEL_BAUD, SEL_TXD, SEL_RXD
  } sel_e;

  function automatic logic [DW-1:0] lane_merge(logic [DW-1:0] old_v,
                                               logic [DW-1:0] new_v,
                                               logic [3:0]    be);
    logic [DW-1:0] r;
    for (int i = 0; i < 4; i++)
      r[8*i +: 8] = be[i] ? new_v[8*i +: 8] : old_v[8*i +: 8];
    return r;
  endfunction

  function automatic logic [DW-1:0] lane_and(logic [DW-1:0] old_v,
                                             logic [DW-1:0] new_v,
                                             logic [3:0]    be);
    logic [DW-1:0] r;
    for (int i = 0; i < 4; i++)
      r[8*i +: 8] = be[i] ? (old_v[8*i +: 8] & new_v[8*i +: 8]) : old_v[8*i +: 8];
    return r;
  endfunction

endpackage

// File: rtl/sio_addr_decode.sv
module sio_addr_decode
  import sio_pkg::*;
#(
  parameter int unsigned WIDX_W = 6
) (
  input  logic [WIDX_W-1:0] widx_i,
  output sel_e              sel_o
);

  always_comb begin
    case (int'(widx_i))
      0:       sel_o = SEL_LCR;
      1:       sel_o = SEL_LSR;
      2:       sel_o = SEL_ICTL;
      3:       sel_o = SEL_STS;
      4:       sel_o = SEL_FCTL;
      5:       sel_o = SEL_BAUD;
      8:       sel_o = SEL_TXD;
      12:      sel_o = SEL_RXD;
      default: sel_o = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/sio_byte_fifo.sv
module sio_byte_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] count_o
);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem_q[wr_ptr_q] <= data_i;
  end

endmodule

// File: rtl/sio_ctrl_regs.sv
module sio_ctrl_regs
  import sio_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned FIFO_DEPTH = 16,
  localparam int unsigned WIDX_W = ADDR_W - 2,
  localparam int unsigned CNT_W  = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  input  logic              tx_ready_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  output logic              rx_ready_o,
  output logic              irq_o
);

  sel_e        sel;
  logic        wr, rd;
  logic [31:0] lcr_q, ictl_q, sts_q, fctl_q, baud_q;
  logic [31:0] sts_d, fctl_nxt, sts_set;
  logic        fctl_wr, clr_rx, clr_tx;
  logic        tx_push, tx_pop, tx_empty, tx_full;
  logic        rx_push, rx_pop, rx_empty, rx_full;
  logic [7:0]  rx_head;
  logic [CNT_W-1:0] tx_count, rx_count;
  logic        unused_addr_lsb;

  assign unused_addr_lsb = ^addr_i[1:0];

  sio_addr_decode #(.WIDX_W(WIDX_W)) i_dec (
    .widx_i (addr_i[ADDR_W-1:2]),
    .sel_o  (sel)
  );

  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;

  // FIFO control: clear only when enable and per-FIFO bit both set after merge
  assign fctl_wr  = wr && (sel == SEL_FCTL);
  assign fctl_nxt = lane_merge(fctl_q, wdata_i, be_i) & FCTL_MASK;
  assign clr_rx   = fctl_wr && fctl_nxt[BIT_FEN] && fctl_nxt[BIT_FRX];
  assign clr_tx   = fctl_wr && fctl_nxt[BIT_FEN] && fctl_nxt[BIT_FTX];

  assign tx_push = wr && (sel == SEL_TXD) && be_i[3];
  assign tx_pop  = tx_valid_o && tx_ready_i;
  assign rx_push = rx_valid_i && rx_ready_o;
  assign rx_pop  = rd && (sel == SEL_RXD) && be_i[3] && !rx_empty;

  sio_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) i_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_tx),
    .push_i  (tx_push),
    .data_i  (wdata_i[31:24]),
    .pop_i   (tx_pop),
    .data_o  (tx_data_o),
    .empty_o (tx_empty),
    .full_o  (tx_full),
    .count_o (tx_count)
  );

  sio_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) i_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_rx),
    .push_i  (rx_push),
    .data_i  (rx_data_i),
    .pop_i   (rx_pop),
    .data_o  (rx_head),
    .empty_o (rx_empty),
    .full_o  (rx_full),
    .count_o (rx_count)
  );

  assign tx_valid_o = !tx_empty;
  assign rx_ready_o = !rx_full;

  // Flags set from registered FIFO state; a status write only clears
  always_comb begin
    sts_set = '0;
    sts_set[BIT_RX] = !rx_empty;
    sts_set[BIT_TX] = tx_empty;
    if (wr && (sel == SEL_STS)) sts_d = lane_and(sts_q, wdata_i, be_i) & STS_MASK;
    else                        sts_d = sts_q | sts_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcr_q  <= LCR_RST;
      ictl_q <= '0;
      sts_q  <= '0;
      fctl_q <= '0;
      baud_q <= BAUD_RST;
    end else begin
      sts_q <= sts_d;
      if (wr && (sel == SEL_LCR))  lcr_q  <= lane_merge(lcr_q,  wdata_i, be_i) & LCR_MASK;
      if (wr && (sel == SEL_ICTL)) ictl_q <= lane_merge(ictl_q, wdata_i, be_i) & ICTL_MASK;
      if (fctl_wr)                 fctl_q <= fctl_nxt;
      if (wr && (sel == SEL_BAUD)) baud_q <= lane_merge(baud_q, wdata_i, be_i) & BAUD_MASK;
    end
  end

  assign irq_o = |(sts_q[BIT_ERR:BIT_RX] & ictl_q[BIT_ERR:BIT_RX]);

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      case (sel)
        SEL_LCR:  rdata_o = lcr_q;
        SEL_ICTL: rdata_o = ictl_q;
        SEL_STS:  rdata_o = sts_q;
        SEL_FCTL: rdata_o = fctl_q;
        SEL_BAUD: rdata_o = baud_q;
        SEL_RXD:  rdata_o = (be_i[3] && !rx_empty) ? {rx_head, 24'h0} : '0;
        default:  rdata_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/sio_ctrl_regs_chk.sv
module sio_ctrl_regs_chk #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned FIFO_DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       rdata_o,
  input logic              tx_valid_o,
  input logic [7:0]        tx_data_o,
  input logic              tx_ready_i,
  input logic              irq_o,
  input logic [31:0]       sts_q,
  input logic [CNT_W-1:0]  tx_count,
  input logic [CNT_W-1:0]  rx_count
);

  logic [ADDR_W-3:0] widx;
  logic unmapped, wr_sts, wr_ictl, wr_fctl;

  assign widx     = addr_i[ADDR_W-1:2];
  assign unmapped = !(widx inside {0, 1, 2, 3, 4, 5, 8, 12});
  assign wr_sts   = req_i && we_i && (widx == 3);
  assign wr_ictl  = req_i && we_i && (widx == 2);
  assign wr_fctl  = req_i && we_i && (widx == 4);

  p_unmapped_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && unmapped) |-> (rdata_o == 32'h0));

  p_sts_clear_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sts |=> ((sts_q & ~$past(sts_q)) == 32'h0));

  p_irq_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !wr_sts && !wr_ictl) |=> irq_o);

  p_tx_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !wr_fctl) |=> (tx_valid_o && $stable(tx_data_o)));

  p_no_overflow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_count <= CNT_W'(FIFO_DEPTH)) && (tx_count <= CNT_W'(FIFO_DEPTH)));

endmodule

bind sio_ctrl_regs sio_ctrl_regs_chk #(.ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .rdata_o    (rdata_o),
  .tx_valid_o (tx_valid_o),
  .tx_data_o  (tx_data_o),
  .tx_ready_i (tx_ready_i),
  .irq_o      (irq_o),
  .sts_q      (sts_q),
  .tx_count   (tx_count),
  .rx_count   (rx_count)
);

// File: tb/test_sio_ctrl_regs.sv
`timescale 1ns/1ps
module test_sio_ctrl_regs;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [3:0]  be_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        tx_valid_o, tx_ready_i = 1'b0;
  logic [7:0]  tx_data_o;
  logic        rx_valid_i = 1'b0;
  logic [7:0]  rx_data_i = '0;
  logic        rx_ready_o, irq_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  sio_ctrl_regs i_sio_ctrl_regs (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_merge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = be[i] ? n[8*i +: 8] : o[8*i +: 8];
    return r;
  endfunction

  task automatic wr(logic [7:0] a, logic [3:0] be, logic [31:0] d);
    req_i = 1; we_i = 1; addr_i = a; be_i = be; wdata_i = d;
    @(posedge clk_i); #1;
    req_i = 0; we_i = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [3:0] be, output logic [31:0] d);
    req_i = 1; we_i = 0; addr_i = a; be_i = be;
    #2 d = rdata_o;
    @(posedge clk_i); #1;
    req_i = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  logic [31:0] lcr_m, ictl_m, fctl_m, baud_m;

  function automatic logic [31:0] model_rd(logic [7:0] a);
    case (a[7:2])
      6'd0: return lcr_m;
      6'd2: return ictl_m;
      6'd4: return fctl_m;
      6'd5: return baud_m;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_wr(logic [7:0] a, logic [3:0] be, logic [31:0] d);
    case (a[7:2])
      6'd0: lcr_m  = m_merge(lcr_m,  d, be) & 32'hE17F_0000;
      6'd2: ictl_m = m_merge(ictl_m, d, be) & 32'h000F_0000;
      6'd4: fctl_m = m_merge(fctl_m, d, be) & 32'h001F_0000;
      6'd5: baud_m = m_merge(baud_m, d, be) & 32'h03FF_0000;
      default: ;
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  offs [9];
    int          acc, got;
    bit          last_rdy;
    v = $urandom(32'd20240611);
    offs = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h28, 8'hFC};

    idle(3);
    rst_ni = 1;
    idle(2);

    // R1 reset values
    rd(8'h00, 4'hF, v); check("R1 lcr", v, 32'h4000_0000);
    rd(8'h14, 4'hF, v); check("R1 baud", v, 32'h03FF_0000);
    rd(8'h08, 4'hF, v); check("R1 ictl", v, 32'h0);
    rd(8'h10, 4'hF, v); check("R1 fctl", v, 32'h0);
    rd(8'h04, 4'hF, v); check("R1 lsr", v, 32'h0);
    check("R1 irq", irq_o, 0);
    check("R1 tx_valid", tx_valid_o, 0);
    check("R1 rx_ready", rx_ready_o, 1);
    // R5 transmit-empty flag sets after reset
    rd(8'h0C, 4'hF, v); check("R5 sts after reset", v, 32'h0002_0000);

    // R2 R3 R4 R12 random register traffic
    lcr_m = 32'h4000_0000; ictl_m = 0; fctl_m = 0; baud_m = 32'h03FF_0000;
    for (int k = 0; k < 300; k++) begin
      logic [7:0]  a;
      logic [3:0]  be;
      logic [31:0] d;
      a  = offs[$urandom % 9] | 8'($urandom % 4);
      be = 4'($urandom);
      d  = $urandom;
      wr(a, be, d);
      model_wr(a, be, d);
      rd(a, 4'hF, v);
      check("R3 R4 readback", v, model_rd(a));
    end
    rd(8'h00, 4'hF, v); check("R2 lcr after mix", v, lcr_m);
    rd(8'h14, 4'hF, v); check("R12 baud after mix", v, baud_m);
    rd(8'h04, 4'hF, v); check("R4 lsr read-only", v, 32'h0);

    wr(8'h08, 4'hF, 32'h0);
    wr(8'h10, 4'hF, 32'h0);
    wr(8'h14, 4'hF, 32'h0);

    // R9 push only with top lane, in order
    wr(8'h20, 4'h8, 32'h41FF_FFFF);
    wr(8'h20, 4'h7, 32'h5500_0000);
    wr(8'h20, 4'h8, 32'h4200_0000);
    wr(8'h20, 4'hF, 32'h4312_3456);
    check("R12 R9 tx_valid after push", tx_valid_o, 1);
    rd(8'h20, 4'hF, v); check("R9 tx read zero", v, 32'h0);
    tx_ready_i = 1;
    for (int k = 0; k < 3; k++) begin
      #1 check("R9 tx_valid", tx_valid_o, 1);
      check("R9 tx order", tx_data_o, 8'h41 + 8'(k));
      @(posedge clk_i); #1;
    end
    check("R9 tx drained", tx_valid_o, 0);
    tx_ready_i = 0;

    // R9 overfill drops extra pushes
    for (int k = 0; k < 18; k++) wr(8'h20, 4'h8, {8'(k), 24'h0});
    tx_ready_i = 1;
    got = 0;
    for (int k = 0; k < 22; k++) begin
      #1;
      if (tx_valid_o) begin
        check("R9 overfill data", tx_data_o, 8'(got));
        got++;
      end
      @(posedge clk_i); #1;
    end
    tx_ready_i = 0;
    check("R9 overfill count", got, 16);

    // R6 R7 clear-only status and interrupt
    idle(2);
    wr(8'h08, 4'hF, 32'h0002_0000);
    check("R7 irq on tx empty", irq_o, 1);
    wr(8'h0C, 4'hF, 32'h0);
    check("R6 irq after clear", irq_o, 0);
    idle(1);
    check("R6 flag re-sets", irq_o, 1);
    wr(8'h20, 4'h8, 32'h7700_0000);
    wr(8'h0C, 4'h4, 32'h0);
    idle(3);
    rd(8'h0C, 4'hF, v); check("R6 stays clear", v, 32'h0);
    check("R7 irq low", irq_o, 0);
    wr(8'h0C, 4'h4, 32'hFFFF_FFFF);
    rd(8'h0C, 4'hF, v); check("R6 write ones no set", v, 32'h0);
    tx_ready_i = 1;
    idle(4);
    tx_ready_i = 0;

    // R11 receive stream fill
    wr(8'h08, 4'hF, 32'h0);
    acc = 0; last_rdy = 1;
    rx_valid_i = 1;
    for (int k = 0; k < 17; k++) begin
      rx_data_i = 8'hA0 + 8'(k);
      #2 last_rdy = rx_ready_o;
      if (last_rdy) acc++;
      @(posedge clk_i); #1;
    end
    rx_valid_i = 0;
    check("R11 accepted", acc, 16);
    check("R11 ready low when full", last_rdy, 0);
    idle(2);
    rd(8'h0C, 4'hF, v); check("R5 rx flag", v, 32'h0003_0000);
    wr(8'h08, 4'hF, 32'h0008_0000);
    check("R7 dma bit no irq", irq_o, 0);
    rd(8'h08, 4'hF, v); check("R7 dma bit stored", v, 32'h0008_0000);
    wr(8'h08, 4'hF, 32'h0001_0000);
    check("R7 rx irq", irq_o, 1);

    // R10 pops
    rd(8'h30, 4'h7, v); check("R10 low lanes no pop", v, 32'h0);
    rd(8'h30, 4'h8, v); check("R10 first pop", v, 32'hA000_0000);
    for (int k = 1; k < 16; k++) begin
      rd(8'h30, 4'hF, v); check("R10 pop order", v, {8'hA0 + 8'(k), 24'h0});
    end
    rd(8'h30, 4'hF, v); check("R10 empty read", v, 32'h0);
    rd(8'h0C, 4'hF, v); check("R5 rx flag sticky", v & 32'h0001_0000, 32'h0001_0000);
    wr(8'h0C, 4'h4, 32'h0);
    idle(2);
    rd(8'h0C, 4'hF, v); check("R5 rx flag stays clear", v & 32'h0001_0000, 32'h0);
    wr(8'h08, 4'hF, 32'h0);

    // R8 FIFO reset gating
    rx_valid_i = 1;
    for (int k = 0; k < 3; k++) begin
      rx_data_i = 8'h30 + 8'(k);
      @(posedge clk_i); #1;
    end
    rx_valid_i = 0;
    wr(8'h20, 4'h8, 32'h9900_0000);
    wr(8'h20, 4'h8, 32'h9A00_0000);
    wr(8'h10, 4'h4, 32'h0006_0000);
    check("R8 no clear without enable", tx_valid_o, 1);
    wr(8'h10, 4'h4, 32'h0005_0000);
    check("R8 tx cleared", tx_valid_o, 0);
    rd(8'h30, 4'h8, v); check("R8 rx kept", v, 32'h3000_0000);
    wr(8'h10, 4'h4, 32'h0003_0000);
    rd(8'h30, 4'h8, v); check("R8 rx cleared", v, 32'h0);
    rd(8'h10, 4'hF, v); check("R8 fctl value", v, 32'h0003_0000);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule